// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Alarm

This block keeps a 32-bit time count for a larger chip. A 20-bit down-counting prescaler divides the RTC clock into a periodic tick. Each tick advances the count, which is compared with a 32-bit alarm value. Three sticky event flags record a tick, an alarm match and a count wrap. Each flag has its own mask bit, and the masked flags drive the interrupt outputs. All access is through a simple 16-bit register bus. A read strobe returns data one cycle later. A write takes effect at the clock edge where it is presented.

Software changes the count, the alarm and the prescaler reload value through a configuration gate. It sets the configuration bit, writes any of those registers into staging storage, then clears the configuration bit. Clearing it starts a fixed commit window. While the window is open, an idle status bit reads 0 and every bus write is dropped. When the window closes, all staged values are applied together. A commit that changes the count or the reload value also restarts the prescaler. The live prescaler value can be read at any time without stopping the count.

Top module: `rtc_timebase`

## Requirements
- R1: After reset, the registers read as follows. Status (0x04) = 0x0020. Mask (0x00) = 0. Reload high (0x08) = 0. Reload low (0x0C) = 0x8000. Count (0x18/0x1C) = 0. Alarm (0x20/0x24) = 0xFFFF in each half. Divider high (0x10) = 0. Both interrupt outputs are low.
- R2: The divider (high 0x10, low 0x14) counts down by one every clock. On the cycle after it reads 0 it reloads the active reload value V and the count increments, so ticks are V+1 clocks apart. A commit that changes the count or the reload value loads the divider with the new reload value.
- R3: Writes to the count (0x18 high, 0x1C low), alarm (0x20 high, 0x24 low) and reload (0x08 holds bits 19:16, 0x0C holds bits 15:0) registers are dropped unless status bit 4 (configuration) is 1.
- R4: Staged values become active only when software writes 0 to status bit 4 while it is 1. Until then, reads return the old active values.
- R5: Status bit 5 (idle) reads 0 for exactly 3 cycles after a commit starts. While it is 0, every bus write is dropped.
- R6: Status bit 0 (tick flag) is set on every tick.
- R7: Status bit 1 (alarm flag) is set when a tick advances the count to the alarm value.
- R8: Status bit 2 (wrap flag) is set when a tick takes the count from 0xFFFFFFFF to 0.
- R9: Flags in status bits 0 to 3 are cleared by writing 0 to that bit. Writing 1 leaves a flag unchanged. Bit 3 (sync flag) is set by every tick and by every commit.
- R10: Mask register bits 0, 1 and 2 enable the tick, alarm and wrap flags. `irq_o` is the OR of the enabled flags and `irq_alarm_o` is the alarm flag AND its mask. Both are registered one cycle behind the flags.
- R11: Reserved bits and unmapped offsets read 0. Only mask bits 2:0 and reload-high bits 3:0 are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the bus and the RTC time base |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid the cycle after a read strobe |
| irq_o | output | 1 | OR of the enabled flags |
| irq_alarm_o | output | 1 | Alarm flag AND alarm mask |

## Verification
A wrong divider or reload state shows up at the ports within one tick period. The count then changes one or more cycles early or late, so the bench reads the count on the exact cycles either side of a tick. A wrong commit window or dirty-bit state shows up on the next read. Staged values then appear before the commit or not at all, the idle bit holds for the wrong number of cycles, or a write made during the window lands. Flag or mask errors appear on the interrupt pins one cycle after the flag changes, and the bench samples the pins there.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned BUS_AW = 6;

  localparam logic [BUS_AW-1:0] OFF_MASK   = 6'h00;
  localparam logic [BUS_AW-1:0] OFF_STAT   = 6'h04;
  localparam logic [BUS_AW-1:0] OFF_RLD_HI = 6'h08;
  localparam logic [BUS_AW-1:0] OFF_RLD_LO = 6'h0C;
  localparam logic [BUS_AW-1:0] OFF_DIV_HI = 6'h10;
  localparam logic [BUS_AW-1:0] OFF_DIV_LO = 6'h14;
  localparam logic [BUS_AW-1:0] OFF_CNT_HI = 6'h18;
  localparam logic [BUS_AW-1:0] OFF_CNT_LO = 6'h1C;
  localparam logic [BUS_AW-1:0] OFF_ALM_HI = 6'h20;
  localparam logic [BUS_AW-1:0] OFF_ALM_LO = 6'h24;

  // event flag indices, shared by the status and mask registers
  localparam int unsigned EV_N   = 3;
  localparam int unsigned EV_SEC = 0;
  localparam int unsigned EV_ALM = 1;
  localparam int unsigned EV_OVF = 2;

  // further status bits
  localparam int unsigned ST_SYNC = 3;
  localparam int unsigned ST_CFG  = 4;
  localparam int unsigned ST_IDLE = 5;

  typedef logic [EV_N-1:0] evt_vec_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned     PS_W     = 20,
  parameter logic [PS_W-1:0] PS_RESET = 20'h08000
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            load_i,
  input  logic [PS_W-1:0] load_val_i,
  input  logic [PS_W-1:0] reload_i,
  output logic [PS_W-1:0] div_o,
  output logic            tick_o
);
  logic [PS_W-1:0] div_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)               div_q <= PS_RESET;
    else if (load_i)         div_q <= load_val_i;
    else if (div_q == '0)    div_q <= reload_i;
    else                     div_q <= div_q - 1'b1;
  end

  assign tick_o = (div_q == '0) && !load_i;
  assign div_o  = div_q;

  // R2: a tick always restarts the divider from the active reload value
  a_r2_tick_reload: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |=> (div_q == $past(reload_i)));
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core
  import rtc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             ld_hi_i,
  input  logic             ld_lo_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] alarm_i,
  input  evt_vec_t         clr_i,
  input  logic             clr_sync_i,
  input  logic             sync_set_i,
  output logic [CNT_W-1:0] cnt_o,
  output evt_vec_t         flag_o,
  output logic             sync_o
);
  localparam int unsigned HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  evt_vec_t         set_v;
  evt_vec_t         flag_q;
  logic             sync_q;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (ld_hi_i || ld_lo_i) begin
      cnt_q <= {ld_hi_i ? ld_val_i[CNT_W-1:HALF] : cnt_q[CNT_W-1:HALF],
                ld_lo_i ? ld_val_i[HALF-1:0]     : cnt_q[HALF-1:0]};
    end else if (tick_i) begin
      cnt_q <= cnt_nxt;
    end
  end

  always_comb begin
    set_v         = '0;
    set_v[EV_SEC] = tick_i;
    set_v[EV_ALM] = tick_i && (cnt_nxt == alarm_i);
    set_v[EV_OVF] = tick_i && (&cnt_q);
  end

  for (genvar g = 0; g < EV_N; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) f_q <= 1'b0;
      else       f_q <= (f_q && !clr_i[g]) || set_v[g];
    end
    assign flag_q[g] = f_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q <= 1'b0;
    else       sync_q <= (sync_q && !clr_sync_i) || tick_i || sync_set_i;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
  assign sync_o = sync_q;

  // R6: every tick leaves the tick flag set
  a_r6_sec_on_tick: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_i |=> flag_q[EV_SEC]);
  // R8: a tick at all ones wraps the count and records it
  a_r8_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && (&cnt_q)) |=> (flag_q[EV_OVF] && (cnt_q == '0)));
  // R7: a fresh alarm flag means the count now equals the alarm it was compared with
  a_r7_alarm_match: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(flag_q[EV_ALM]) |-> (cnt_q == $past(alarm_i)));
  // R9: a flag stays set until software clears it
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_q[EV_ALM] && !clr_i[EV_ALM]) |=> flag_q[EV_ALM]);
endmodule

// File: rtl/rtc_cfg_gate.sv
module rtc_cfg_gate
  import rtc_pkg::*;
#(
  parameter int unsigned     DATA_W     = 16,
  parameter int unsigned     PS_W       = 20,
  parameter int unsigned     COMMIT_CYC = 3,
  parameter logic [PS_W-1:0] PS_RESET   = 20'h08000,
  localparam int unsigned    CNT_W      = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output evt_vec_t          mask_o,
  output logic              cfg_o,
  output logic              busy_o,
  output evt_vec_t          clr_o,
  output logic              clr_sync_o,
  output logic              apply_o,
  output logic              ld_cnt_hi_o,
  output logic              ld_cnt_lo_o,
  output logic [CNT_W-1:0]  cnt_val_o,
  output logic              ps_load_o,
  output logic [PS_W-1:0]   rld_o,
  output logic [PS_W-1:0]   rld_next_o,
  output logic [CNT_W-1:0]  alarm_o
);
  localparam int unsigned RH_W   = PS_W - DATA_W;
  localparam int unsigned BUSY_W = $clog2(COMMIT_CYC + 1);

  logic [BUSY_W-1:0] busy_q;
  logic              cfg_q;
  evt_vec_t          mask_q;
  logic [CNT_W-1:0]  stg_cnt, stg_alm, alm_q, alm_next;
  logic [PS_W-1:0]   stg_rld, rld_q, rld_next;
  logic              d_cnt_hi, d_cnt_lo, d_alm_hi, d_alm_lo, d_rld_hi, d_rld_lo;
  logic              wr_ok, stg_ok, stat_wr, exit_cfg, apply;

  assign wr_ok    = sel_i && wr_i && (busy_q == '0);
  assign stg_ok   = wr_ok && cfg_q;
  assign stat_wr  = wr_ok && (addr_i == OFF_STAT);
  assign exit_cfg = stat_wr && cfg_q && !wdata_i[ST_CFG];
  assign apply    = (busy_q == BUSY_W'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_q   <= '0;
      cfg_q    <= 1'b0;
      mask_q   <= '0;
      stg_cnt  <= '0;
      stg_alm  <= '0;
      stg_rld  <= '0;
      alm_q    <= '1;
      rld_q    <= PS_RESET;
      d_cnt_hi <= 1'b0;
      d_cnt_lo <= 1'b0;
      d_alm_hi <= 1'b0;
      d_alm_lo <= 1'b0;
      d_rld_hi <= 1'b0;
      d_rld_lo <= 1'b0;
    end else begin
      if (wr_ok && (addr_i == OFF_MASK)) mask_q <= wdata_i[EV_N-1:0];
      if (stat_wr)                       cfg_q  <= wdata_i[ST_CFG];

      if (exit_cfg)            busy_q <= BUSY_W'(COMMIT_CYC);
      else if (busy_q != '0)   busy_q <= busy_q - 1'b1;

      if (stg_ok && (addr_i == OFF_CNT_HI)) begin
        stg_cnt[CNT_W-1:DATA_W] <= wdata_i;
        d_cnt_hi                <= 1'b1;
      end
      if (stg_ok && (addr_i == OFF_CNT_LO)) begin
        stg_cnt[DATA_W-1:0] <= wdata_i;
        d_cnt_lo            <= 1'b1;
      end
      if (stg_ok && (addr_i == OFF_ALM_HI)) begin
        stg_alm[CNT_W-1:DATA_W] <= wdata_i;
        d_alm_hi                <= 1'b1;
      end
      if (stg_ok && (addr_i == OFF_ALM_LO)) begin
        stg_alm[DATA_W-1:0] <= wdata_i;
        d_alm_lo            <= 1'b1;
      end
      if (stg_ok && (addr_i == OFF_RLD_HI)) begin
        stg_rld[PS_W-1:DATA_W] <= wdata_i[RH_W-1:0];
        d_rld_hi               <= 1'b1;
      end
      if (stg_ok && (addr_i == OFF_RLD_LO)) begin
        stg_rld[DATA_W-1:0] <= wdata_i;
        d_rld_lo            <= 1'b1;
      end

      if (apply) begin
        alm_q    <= alm_next;
        rld_q    <= rld_next;
        d_cnt_hi <= 1'b0;
        d_cnt_lo <= 1'b0;
        d_alm_hi <= 1'b0;
        d_alm_lo <= 1'b0;
        d_rld_hi <= 1'b0;
        d_rld_lo <= 1'b0;
      end
    end
  end

  assign alm_next = {d_alm_hi ? stg_alm[CNT_W-1:DATA_W] : alm_q[CNT_W-1:DATA_W],
                     d_alm_lo ? stg_alm[DATA_W-1:0]     : alm_q[DATA_W-1:0]};
  assign rld_next = {d_rld_hi ? stg_rld[PS_W-1:DATA_W]  : rld_q[PS_W-1:DATA_W],
                     d_rld_lo ? stg_rld[DATA_W-1:0]     : rld_q[DATA_W-1:0]};

  for (genvar g = 0; g < EV_N; g++) begin : g_clr
    assign clr_o[g] = stat_wr && !wdata_i[g];
  end
  assign clr_sync_o = stat_wr && !wdata_i[ST_SYNC];

  assign mask_o      = mask_q;
  assign cfg_o       = cfg_q;
  assign busy_o      = (busy_q != '0);
  assign apply_o     = apply;
  assign ld_cnt_hi_o = apply && d_cnt_hi;
  assign ld_cnt_lo_o = apply && d_cnt_lo;
  assign cnt_val_o   = stg_cnt;
  assign ps_load_o   = apply && (d_cnt_hi || d_cnt_lo || d_rld_hi || d_rld_lo);
  assign rld_o       = rld_q;
  assign rld_next_o  = rld_next;
  assign alarm_o     = alm_q;

  // R5: a write presented while the commit window is open changes no mask bit
  a_r5_busy_drops_write: assert property (@(posedge clk_i) disable iff (rst_i)
    ((busy_q != '0) && sel_i && wr_i && (addr_i == OFF_MASK)) |=> $stable(mask_q));
  // R5: the commit window only opens when configuration mode is left
  a_r5_window_on_exit: assert property (@(posedge clk_i) disable iff (rst_i)
    ((busy_q != '0) && $past(busy_q == '0)) |-> ($past(cfg_q) && !cfg_q));
  // R3: outside configuration mode the staging storage never moves
  a_r3_no_stage: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cfg_q && sel_i && wr_i) |=> ($stable(stg_cnt) && $stable(stg_alm) && $stable(stg_rld)));
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_pkg::*;
#(
  parameter int unsigned     DATA_W     = 16,
  parameter int unsigned     PS_W       = 20,
  parameter int unsigned     COMMIT_CYC = 3,
  parameter logic [PS_W-1:0] PS_RESET   = 20'h08000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              irq_alarm_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;
  localparam int unsigned RH_W  = PS_W - DATA_W;

  evt_vec_t          mask, clr, flags;
  logic              cfg, busy, clr_sync, apply, ld_hi, ld_lo, ps_load, tick, sync;
  logic [CNT_W-1:0]  stg_cnt, alarm, cnt;
  logic [PS_W-1:0]   rld, rld_next, div;
  logic [DATA_W-1:0] rd_mux, rdata_q;
  logic              irq_q, irq_alm_q;

  rtc_cfg_gate #(
    .DATA_W(DATA_W), .PS_W(PS_W), .COMMIT_CYC(COMMIT_CYC), .PS_RESET(PS_RESET)
  ) u_cfg (
    .clk_i(clk_i), .rst_i(rst_i),
    .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .mask_o(mask), .cfg_o(cfg), .busy_o(busy), .clr_o(clr), .clr_sync_o(clr_sync),
    .apply_o(apply), .ld_cnt_hi_o(ld_hi), .ld_cnt_lo_o(ld_lo), .cnt_val_o(stg_cnt),
    .ps_load_o(ps_load), .rld_o(rld), .rld_next_o(rld_next), .alarm_o(alarm)
  );

  rtc_prescaler #(.PS_W(PS_W), .PS_RESET(PS_RESET)) u_ps (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(ps_load), .load_val_i(rld_next),
    .reload_i(rld), .div_o(div), .tick_o(tick)
  );

  rtc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .ld_hi_i(ld_hi), .ld_lo_i(ld_lo),
    .ld_val_i(stg_cnt), .alarm_i(alarm), .clr_i(clr), .clr_sync_i(clr_sync),
    .sync_set_i(apply), .cnt_o(cnt), .flag_o(flags), .sync_o(sync)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr_i)
      OFF_MASK:   rd_mux[EV_N-1:0] = mask;
      OFF_STAT: begin
        rd_mux[EV_N-1:0] = flags;
        rd_mux[ST_SYNC]  = sync;
        rd_mux[ST_CFG]   = cfg;
        rd_mux[ST_IDLE]  = !busy;
      end
      OFF_RLD_HI: rd_mux[RH_W-1:0] = rld[PS_W-1:DATA_W];
      OFF_RLD_LO: rd_mux = rld[DATA_W-1:0];
      OFF_DIV_HI: rd_mux[RH_W-1:0] = div[PS_W-1:DATA_W];
      OFF_DIV_LO: rd_mux = div[DATA_W-1:0];
      OFF_CNT_HI: rd_mux = cnt[CNT_W-1:DATA_W];
      OFF_CNT_LO: rd_mux = cnt[DATA_W-1:0];
      OFF_ALM_HI: rd_mux = alarm[CNT_W-1:DATA_W];
      OFF_ALM_LO: rd_mux = alarm[DATA_W-1:0];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q   <= '0;
      irq_q     <= 1'b0;
      irq_alm_q <= 1'b0;
    end else begin
      if (bus_sel_i && !bus_wr_i) rdata_q <= rd_mux;
      irq_q     <= |(flags & mask);
      irq_alm_q <= flags[EV_ALM] && mask[EV_ALM];
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
  assign irq_alarm_o = irq_alm_q;

  // R10: the alarm pin follows the enabled alarm flag one cycle later
  a_r10_irq_alarm: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_alarm_o |-> $past(flags[EV_ALM] && mask[EV_ALM]));
  // R10: the summary pin is low whenever no enabled flag was set the cycle before
  a_r10_irq_any: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(|(flags & mask)) |-> !irq_o);
endmodule

// File: tb/rtc_timebase_tb.sv
`timescale 1ns/1ps
module rtc_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, irq_alm;
  int          n_chk = 0;
  int          n_fail = 0;

  localparam logic [5:0] A_MASK = 6'h00, A_STAT = 6'h04, A_RH = 6'h08, A_RL = 6'h0C,
                         A_DH = 6'h10, A_DL = 6'h14, A_CH = 6'h18, A_CL = 6'h1C,
                         A_AH = 6'h20, A_AL = 6'h24;

  // {offset, value written in configuration mode, value read back after commit}
  localparam logic [37:0] VEC [8] = '{
    {A_CH,   16'h1234, 16'h1234},  // R4
    {A_CL,   16'hABCD, 16'hABCD},  // R4
    {A_AH,   16'h0F0F, 16'h0F0F},  // R4
    {A_RH,   16'hFFF5, 16'h0005},  // R11 only 4 bits kept
    {A_RH,   16'h0000, 16'h0000},
    {A_RL,   16'h7FFF, 16'h7FFF},
    {A_MASK, 16'hFFFF, 16'h0007},  // R11 only 3 bits kept
    {A_MASK, 16'h0000, 16'h0000}
  };

  rtc_timebase dut_i (
    .clk_i(clk), .rst_i(rst), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .irq_alarm_o(irq_alm)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int k = 0; k < 20; k++) begin
      bus_rd(A_STAT, s);
      if (s[5]) break;
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] v, v2;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {14'b0, irq, irq_alm}, 16'h0000);
    bus_rd(A_STAT, v); check("R1 status", v, 16'h0020);
    bus_rd(A_MASK, v); check("R1 mask", v, 16'h0000);
    bus_rd(A_RH, v);   check("R1 reload hi", v, 16'h0000);
    bus_rd(A_RL, v);   check("R1 reload lo", v, 16'h8000);
    bus_rd(A_CL, v);   check("R1 count lo", v, 16'h0000);
    bus_rd(A_AH, v);   check("R1 alarm hi", v, 16'hFFFF);
    bus_rd(A_AL, v);   check("R1 alarm lo", v, 16'hFFFF);
    bus_rd(A_DH, v);   check("R1 divider hi", v, 16'h0000);
    // R2 divider runs without stopping, one step per clock
    bus_rd(A_DL, v); bus_rd(A_DL, v2);
    check("R2 divider step", v - v2, 16'h0001);
    check("R2 divider range", {8'h00, v[15:8]}, 16'h007F);
    bus_rd(6'h28, v); check("R11 unmapped", v, 16'h0000);
    // R9 writing ones to the flags sets nothing
    bus_wr(A_STAT, 16'h000F);
    bus_rd(A_STAT, v); check("R9 write one", v, 16'h0020);

    // table: stage, commit, read back
    for (int i = 0; i < 8; i++) begin
      bus_wr(A_STAT, 16'h0010);
      bus_wr(VEC[i][37:32], VEC[i][31:16]);
      bus_wr(A_STAT, 16'h0000);
      wait_idle();
      bus_rd(VEC[i][37:32], v);
      check($sformatf("R4/R11 table %0d", i), v, VEC[i][15:0]);
    end

    // R3 write outside configuration mode is dropped
    bus_wr(A_CL, 16'h5555);
    bus_rd(A_CL, v); check("R3 count unchanged", v, 16'hABCD);

    // R4 staged value hidden until exit; R5 idle window and dropped write
    bus_wr(A_STAT, 16'h0010);
    bus_wr(A_AL, 16'h1111);
    bus_rd(A_AL, v); check("R4 before commit", v, 16'hFFFF);
    bus_wr(A_STAT, 16'h0000);              // commit starts (edge E0)
    bus_rd(A_STAT, v); check("R5 idle low E1", {15'b0, v[5]}, 16'h0000);
    bus_wr(A_MASK, 16'h0007);              // E2, inside window
    bus_rd(A_STAT, v); check("R5 idle low E3", {15'b0, v[5]}, 16'h0000);
    bus_rd(A_STAT, v); check("R5 idle back E4", {15'b0, v[5]}, 16'h0001);
    bus_rd(A_MASK, v); check("R5 write dropped", v, 16'h0000);
    bus_rd(A_AL, v);   check("R4 after commit", v, 16'h1111);

    // fast time base: reload 4, count 0xFFFFFFFE, alarm 0xFFFFFFFF
    bus_wr(A_STAT, 16'h0010);
    bus_wr(A_RH, 16'h0000);
    bus_wr(A_RL, 16'h0004);
    bus_wr(A_CH, 16'hFFFF);
    bus_wr(A_CL, 16'hFFFE);
    bus_wr(A_AH, 16'hFFFF);
    bus_wr(A_AL, 16'hFFFF);
    bus_wr(A_STAT, 16'h0000);              // E0, apply at E3, ticks at E8, E13
    repeat (7) @(negedge clk);
    bus_rd(A_CL, v); check("R2 before tick", v, 16'hFFFE);
    bus_rd(A_CL, v); check("R2 on tick", v, 16'hFFFF);
    repeat (5) @(negedge clk);
    bus_rd(A_CH, v); check("R8 wrapped hi", v, 16'h0000);
    bus_rd(A_STAT, v); check("R6/R7/R8/R9 flags", v, 16'h002F);

    // R10 masks and interrupt pins
    check("R10 masked", {14'b0, irq, irq_alm}, 16'h0000);
    bus_wr(A_MASK, 16'h0002);
    @(negedge clk);
    check("R10 alarm enabled", {14'b0, irq, irq_alm}, 16'h0003);
    bus_wr(A_STAT, 16'h000D);              // clear only the alarm flag
    @(negedge clk);
    check("R10 alarm cleared", {14'b0, irq, irq_alm}, 16'h0000);
    bus_rd(A_STAT, v); check("R9 alarm flag clear", {15'b0, v[1]}, 16'h0000);
    bus_wr(A_MASK, 16'h0004);
    @(negedge clk);
    check("R10 wrap enabled", {14'b0, irq, irq_alm}, 16'h0002);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule